// File: doc/BRIEF.md
# External Interrupt Request Detector

This block turns one active-low external interrupt pin into a request flag for an interrupt controller. The raw pin is first brought into the clock domain by a short flop chain. It is then sampled only on cycles where a machine-cycle strobe is high, so the request logic sees at most one new pin value per machine cycle.

A mode input picks one of two behaviours. In level mode the flag tracks the inverted sampled pin: it is high while the pin is low and drops on its own once the pin is seen high again. In this mode software writes and the controller's vector acknowledge have no effect on the flag. In edge mode the flag is sticky. A sample that reads high followed by a sample that reads low sets it. The controller's acknowledge clears it, and software may also set or clear it through a one-bit write port.

The same flag value drives both the request output to the controller and the readable value for software.

Top module: `ext_irq_detect`

## Requirements
- R1: The pin passes through a two-flop synchroniser and is sampled only in cycles where `mc_strobe_i` is 1. A low pulse on the pin that never reaches a strobe cycle leaves the flag at 0 in both modes.
- R2: With `edge_mode_i` = 0, the flag is 1 while the last sample of the pin is 0 and returns to 0 once a sample reads 1. `req_o` and `flag_rd_o` both carry the flag.
- R3: With `edge_mode_i` = 0, a software write (`sw_wr_i` = 1, any `sw_wdata_i`) leaves the flag unchanged.
- R4: With `edge_mode_i` = 0, `vec_ack_i` does not clear the flag. While the pin stays low, the flag stays 1.
- R5: With `edge_mode_i` = 0, a low level that ends before any strobe samples it produces no request.
- R6: With `edge_mode_i` = 1, the flag is set when a sample reads 0 and the previous sample read 1. The flag stays 1 after the pin returns high. A pin held low gives no further set.
- R7: With `edge_mode_i` = 1, a `vec_ack_i` pulse clears the flag in the next cycle.
- R8: With `edge_mode_i` = 1, a software write loads `sw_wdata_i` into the flag (1 sets it, 0 clears it).
- R9: With `edge_mode_i` = 1, an edge set in the same cycle as a software clear or an acknowledge leaves the flag at 1.
- R10: After reset the flag is 0 and the previous-sample register reads high, so a pin resting high produces no edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_n_i | input | 1 | Raw active-low interrupt pin, asynchronous |
| edge_mode_i | input | 1 | 0 = level-triggered, 1 = falling-edge-triggered |
| mc_strobe_i | input | 1 | One-cycle pulse per machine cycle; the pin is sampled when it is high |
| vec_ack_i | input | 1 | Controller acknowledge that the vector call has started |
| sw_wr_i | input | 1 | Software write strobe for the flag |
| sw_wdata_i | input | 1 | Software write value for the flag |
| req_o | output | 1 | Request flag to the interrupt controller |
| flag_rd_o | output | 1 | Flag value for software read |

## Verification
A wrong sample or previous-sample register shows up at `req_o` one clock after the next strobe. It appears either as a missing request or as a spurious one after a pin that rests high. An edge that is missed or counted twice shows as a sticky flag that is absent, or that comes back after an acknowledge while the pin is held low. Because the flag has no path back into the sampler, a corrupted flag in edge mode persists until an acknowledge or software write. In level mode the same fault is overwritten at the next clock.

// File: rtl/irq_det_pkg.sv
package irq_det_pkg;

    // Sampler state: last strobe-time sample and the one-cycle edge pulse
    typedef struct packed {
        logic samp;
        logic fall;
    } smp_state_t;

    localparam logic PIN_IDLE = 1'b1;

endpackage

// File: rtl/irq_det_sync.sv
module irq_det_sync #(
    parameter int   STAGES    = 2,
    parameter logic RESET_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic sync_o
);
    logic [STAGES-1:0] chain_d, chain_q;

    always_comb begin
        chain_d[0] = async_i;
        for (int i = 1; i < STAGES; i++) begin
            chain_d[i] = chain_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= {STAGES{RESET_VAL}};
        else        chain_q <= chain_d;
    end

    assign sync_o = chain_q[STAGES-1];

endmodule

// File: rtl/irq_det_sampler.sv
module irq_det_sampler
    import irq_det_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic strobe_i,
    input  logic pin_s_i,
    output logic low_o,
    output logic fall_o
);
    smp_state_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        s_d.fall = 1'b0;
        if (strobe_i) begin
            s_d.samp = pin_s_i;
            s_d.fall = s_q.samp & ~pin_s_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{samp: PIN_IDLE, fall: 1'b0};
        else        s_q <= s_d;
    end

    assign low_o  = ~s_q.samp;
    assign fall_o = s_q.fall;

    // R1: the sample only moves on strobe cycles
    assert_hold_between_strobes_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !strobe_i |=> $stable(s_q.samp));

    // R6: an edge pulse only follows a strobe cycle
    assert_edge_after_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.fall |-> $past(strobe_i));

endmodule

// File: rtl/irq_det_flag.sv
module irq_det_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic edge_mode_i,
    input  logic level_low_i,
    input  logic fall_i,
    input  logic ack_i,
    input  logic sw_wr_i,
    input  logic sw_wdata_i,
    output logic flag_o
);
    logic flag_d, flag_q;

    always_comb begin
        flag_d = flag_q;
        if (!edge_mode_i) begin
            flag_d = level_low_i;
        end else if (fall_i) begin
            flag_d = 1'b1;
        end else if (ack_i) begin
            flag_d = 1'b0;
        end else if (sw_wr_i) begin
            flag_d = sw_wdata_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flag_q <= 1'b0;
        else        flag_q <= flag_d;
    end

    assign flag_o = flag_q;

    assert_sw_ignored_level_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!edge_mode_i && sw_wr_i && !level_low_i) |=> !flag_q);

    assert_ack_keeps_level_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!edge_mode_i && ack_i && level_low_i) |=> flag_q);

    assert_ack_clears_edge_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_mode_i && ack_i && !fall_i) |=> !flag_q);

    assert_edge_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_mode_i && fall_i) |=> flag_q);

endmodule

// File: rtl/ext_irq_detect.sv
module ext_irq_detect #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_n_i,
    input  logic edge_mode_i,
    input  logic mc_strobe_i,
    input  logic vec_ack_i,
    input  logic sw_wr_i,
    input  logic sw_wdata_i,
    output logic req_o,
    output logic flag_rd_o
);
    import irq_det_pkg::*;

    logic pin_s, level_low, fall, flag;

    irq_det_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(PIN_IDLE)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_i(pin_n_i), .sync_o(pin_s)
    );

    irq_det_sampler u_smp (
        .clk(clk), .rst_n(rst_n), .strobe_i(mc_strobe_i), .pin_s_i(pin_s),
        .low_o(level_low), .fall_o(fall)
    );

    irq_det_flag u_flag (
        .clk(clk), .rst_n(rst_n), .edge_mode_i(edge_mode_i),
        .level_low_i(level_low), .fall_i(fall), .ack_i(vec_ack_i),
        .sw_wr_i(sw_wr_i), .sw_wdata_i(sw_wdata_i), .flag_o(flag)
    );

    assign req_o     = flag;
    assign flag_rd_o = flag;

endmodule

// File: tb/tb_ext_irq_detect.sv
module tb_ext_irq_detect;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pin_n = 1'b1, mode = 1'b0, strobe = 1'b0, ack = 1'b0, sw_wr = 1'b0, sw_wd = 1'b0;
    logic req, flag_rd;
    int checks = 0, fails = 0;
    bit done = 0;

    always #2 clk = ~clk;

    ext_irq_detect dut (
        .clk(clk), .rst_n(rst_n), .pin_n_i(pin_n), .edge_mode_i(mode),
        .mc_strobe_i(strobe), .vec_ack_i(ack), .sw_wr_i(sw_wr), .sw_wdata_i(sw_wd),
        .req_o(req), .flag_rd_o(flag_rd)
    );

    task automatic chk(string r, logic exp);
        checks++;
        if (req !== exp || flag_rd !== exp) begin
            fails++;
            $display("FAIL %s: req=%b rd=%b expected %b", r, req, flag_rd, exp);
        end
    endtask

    task automatic mc(int n);
        for (int i = 0; i < n; i++) begin
            strobe = 1'b1; @(negedge clk);
            strobe = 1'b0; repeat (3) @(negedge clk);
        end
    endtask

    task automatic sw_write(logic v);
        sw_wr = 1'b1; sw_wd = v; @(negedge clk);
        sw_wr = 1'b0; @(negedge clk);
    endtask

    task automatic pulse_ack();
        ack = 1'b1; @(negedge clk);
        ack = 1'b0;
    endtask

    task automatic t_reset();
        chk("R10 reset flag", 1'b0);
        mc(3);
        chk("R10 idle high pin no edge", 1'b0);
    endtask

    task automatic t_level();
        mode = 1'b0; pin_n = 1'b0; mc(3);
        chk("R2 level low sets", 1'b1);
        sw_write(1'b0);
        chk("R3 sw clear ignored", 1'b1);
        pulse_ack(); @(negedge clk);
        chk("R4 ack keeps level", 1'b1);
        mc(2);
        chk("R4 still low still set", 1'b1);
        pin_n = 1'b1; mc(3);
        chk("R2 level high clears", 1'b0);
        sw_write(1'b1);
        chk("R3 sw set ignored", 1'b0);
    endtask

    task automatic glitch(logic m, string r);
        mode = m; strobe = 1'b0;
        pin_n = 1'b0; @(negedge clk);
        pin_n = 1'b1; repeat (5) @(negedge clk);
        mc(3);
        chk(r, 1'b0);
    endtask

    task automatic t_edge();
        mode = 1'b1; pin_n = 1'b1; mc(3);
        chk("R10 edge mode no false edge", 1'b0);
        pin_n = 1'b0; mc(3);
        chk("R6 falling edge sets", 1'b1);
        pin_n = 1'b1; mc(3);
        chk("R6 sticky after high", 1'b1);
        pulse_ack(); @(negedge clk);
        chk("R7 ack clears", 1'b0);
        pin_n = 1'b0; mc(3);
        chk("R6 second edge sets", 1'b1);
        pulse_ack(); mc(3);
        chk("R6 held low no new set", 1'b0);
        pin_n = 1'b1; mc(3);
    endtask

    task automatic t_sw();
        mode = 1'b1;
        sw_write(1'b1);
        chk("R8 sw set", 1'b1);
        sw_write(1'b0);
        chk("R8 sw clear", 1'b0);
    endtask

    task automatic t_race();
        mode = 1'b1; pin_n = 1'b1; mc(3);
        chk("R9 precondition clear", 1'b0);
        pin_n = 1'b0;
        mc(1);
        strobe = 1'b1; @(negedge clk);
        strobe = 1'b0; sw_wr = 1'b1; sw_wd = 1'b0; ack = 1'b1;
        @(negedge clk);
        sw_wr = 1'b0; ack = 1'b0;
        chk("R9 edge beats sw clear and ack", 1'b1);
        pin_n = 1'b1; mc(3);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog: run=hung expected=done");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_level();
        glitch(1'b0, "R5 short low lost (R1)");
        glitch(1'b1, "R1 unsampled pulse ignored in edge mode");
        t_edge();
        t_sw();
        t_race();
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule